// File: doc/BRIEF.md
# Dual-Channel IDE Interrupt Status Unit

This block owns the interrupt-related configuration bytes of a two-channel IDE host controller and produces the single level-sensitive interrupt line that the controller presents on its PCI bus. Each drive channel raises and lowers a request input. The block records each channel's pending state in two configuration locations: a per-channel status byte and a shared mode byte. It keeps the two copies equal no matter which one software writes.

Software reaches the block through a dword-wide configuration port carrying a byte address, byte enables and write data. Reads are also served by this port, one cycle after the request. Pending bits are write-one-to-clear from software and cannot be set by it. The shared mode byte also holds one block bit per channel. A set block bit stops that channel's pending state from reaching the interrupt line, but the pending bit itself is kept. The unit also returns the reset values of the channel-enable byte, the interrupt-pin byte and the programming-interface byte. A strap input decides at reset whether the second channel is reported as enabled.

Top module: `ide_irq_status_unit`

## Requirements
- R1: While reset is high, and after it falls, all pending bits read 0, both block bits read 0 and `irq_out` is 0.
- R2: The configuration read values are fixed. Offset 0x09 reads 0x8F and offset 0x3D reads 0x01. Offset 0x51 reads 0x04, or 0x0C when `strap_sec_en` was high during reset. Writes to these three bytes have no effect.
- R3: A request edge acts on the channel's pending bit in both locations. A rising edge (request 0 in one cycle, 1 in the next) sets it. A falling edge clears it. The request level is tracked during reset, so a level held through reset is not an edge.
- R4: The channel 0 status byte is offset 0x50, with pending in bit 2. The channel 1 status byte is offset 0x57, with pending in bit 4. Writing 1 to one of these bits clears it, and writing 0 leaves it unchanged. After the write, the matching bit in the mode byte equals the status-byte bit.
- R5: The mode byte is offset 0x71. It holds channel 0 pending in bit 2 and channel 1 pending in bit 3, both write-one-to-clear. After a write to this byte, the status bytes at 0x50 and 0x57 follow it.
- R6: Mode byte bits 4 and 5 are the block bits for channel 0 and channel 1. They are read/write. `irq_out` equals (pending0 AND NOT block0) OR (pending1 AND NOT block1).
- R7: `irq_out` is registered. It changes on the first clock edge that samples the write or request change that causes it, and never before that edge.
- R8: When a request edge and a clearing write reach the same channel in one cycle, the request edge decides the result.
- R9: A read returns all four bytes of the addressed dword on `cfg_rdata` one clock after `cfg_rd` is sampled high. Byte lane k holds byte address (`cfg_addr` with its low two bits replaced by k). Unlisted offsets read 0. Unused bits of the status and mode bytes read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| strap_sec_en | input | 1 | Reports the second channel as enabled; sampled during reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_rd | input | 1 | Configuration read strobe |
| cfg_addr | input | 8 | Configuration byte address of the dword; low two bits ignored |
| cfg_be | input | 4 | Write byte enables, one per lane |
| cfg_wdata | input | 32 | Write data, lane k in bits 8k+7..8k |
| cfg_rdata | output | 32 | Registered read data |
| chan_req | input | 2 | Per-channel interrupt request levels |
| irq_out | output | 1 | Registered level-sensitive interrupt |

## Verification
The bench targets four risks. Writing zero to a pending bit must not clear it. A clear made through one location must appear in the other. A request edge must beat a clear that arrives in the same cycle. A blocked channel must keep its pending bit while the interrupt line stays low. A design that got these wrong would show one of the following: a status byte and the mode byte reading differently, an interrupt lost after a simultaneous clear, or an interrupt raised while blocked. The bench also probes `irq_out` half a cycle before each edge, which catches a combinational path that bypasses the output register. Random writes across the owned and read-only dwords, with sparse request toggles, exercise the clear-and-mirror paths against a bench model.

// File: rtl/ide_irq_pkg.sv
package ide_irq_pkg;
  localparam int NUM_CHAN = 2;

  // Byte offsets that other agents decode
  localparam logic [7:0] OFS_PROGIF  = 8'h09;
  localparam logic [7:0] OFS_INTPIN  = 8'h3D;
  localparam logic [7:0] OFS_CH0STAT = 8'h50;
  localparam logic [7:0] OFS_CHEN    = 8'h51;
  localparam logic [7:0] OFS_CH1STAT = 8'h57;
  localparam logic [7:0] OFS_MODE    = 8'h71;

  // Bit positions inside those bytes
  localparam int BIT_CH0STAT    = 2;
  localparam int BIT_CH1STAT    = 4;
  localparam int BIT_MODE_PEND0 = 2;  // channel 1 at +1
  localparam int BIT_MODE_BLK0  = 4;  // channel 1 at +1

  localparam logic [7:0] PROGIF_VAL = 8'h8F;
  localparam logic [7:0] INTPIN_VAL = 8'h01;
  localparam logic [7:0] CHEN_BASE  = 8'h04;
  localparam logic [7:0] CHEN_SEC   = 8'h08;

  typedef struct packed {
    logic [NUM_CHAN-1:0] clr_stat;   // clear requests at the status bytes
    logic [NUM_CHAN-1:0] clr_mode;   // clear requests at the mode byte
    logic                touch_stat; // a status byte was written
    logic                touch_mode; // the mode byte was written
    logic                blk_we;
    logic [NUM_CHAN-1:0] blk_val;
  } wr_cmd_t;
endpackage

// File: rtl/ide_irq_wr_decode.sv
module ide_irq_wr_decode
  import ide_irq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_BYTES = 4
) (
  input  logic                    cfg_wr,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [DATA_BYTES-1:0]   cfg_be,
  input  logic [8*DATA_BYTES-1:0] cfg_wdata,
  output wr_cmd_t                 cmd
);
  localparam int LANE_W = $clog2(DATA_BYTES);

  logic [DATA_BYTES-1:0] hit_s0, hit_s1, hit_md;
  logic [DATA_BYTES-1:0] bit_s0, bit_s1, bit_m0, bit_m1, bit_b0, bit_b1;

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
    logic [ADDR_W-1:0] lane_addr;
    logic [7:0]        lane_byte;
    logic              lane_on;
    assign lane_addr = {cfg_addr[ADDR_W-1:LANE_W], LANE_W'(g)};
    assign lane_byte = cfg_wdata[8*g +: 8];
    assign lane_on   = cfg_wr & cfg_be[g];
    assign hit_s0[g] = lane_on && (lane_addr == ADDR_W'(OFS_CH0STAT));
    assign hit_s1[g] = lane_on && (lane_addr == ADDR_W'(OFS_CH1STAT));
    assign hit_md[g] = lane_on && (lane_addr == ADDR_W'(OFS_MODE));
    assign bit_s0[g] = lane_byte[BIT_CH0STAT];
    assign bit_s1[g] = lane_byte[BIT_CH1STAT];
    assign bit_m0[g] = lane_byte[BIT_MODE_PEND0];
    assign bit_m1[g] = lane_byte[BIT_MODE_PEND0+1];
    assign bit_b0[g] = lane_byte[BIT_MODE_BLK0];
    assign bit_b1[g] = lane_byte[BIT_MODE_BLK0+1];
  end

  always_comb begin
    cmd.touch_stat  = |(hit_s0 | hit_s1);
    cmd.touch_mode  = |hit_md;
    cmd.clr_stat[0] = |(hit_s0 & bit_s0);
    cmd.clr_stat[1] = |(hit_s1 & bit_s1);
    cmd.clr_mode[0] = |(hit_md & bit_m0);
    cmd.clr_mode[1] = |(hit_md & bit_m1);
    cmd.blk_we      = |hit_md;
    cmd.blk_val[0]  = |(hit_md & bit_b0);
    cmd.blk_val[1]  = |(hit_md & bit_b1);
  end

  logic unused_lane_bits;
  assign unused_lane_bits = ^cfg_addr[LANE_W-1:0];
endmodule

// File: rtl/ide_irq_pend_core.sv
module ide_irq_pend_core
  import ide_irq_pkg::*;
(
  input  logic                clk,
  input  logic                rst,
  input  wr_cmd_t             cmd,
  input  logic [NUM_CHAN-1:0] chan_req,
  output logic [NUM_CHAN-1:0] pend_stat,
  output logic [NUM_CHAN-1:0] pend_mode,
  output logic [NUM_CHAN-1:0] blk,
  output logic [NUM_CHAN-1:0] pend_next,
  output logic [NUM_CHAN-1:0] blk_next
);
  logic [NUM_CHAN-1:0] req_q;
  logic [NUM_CHAN-1:0] stat_nx, mode_nx;

  // Request history follows the input during reset too: no false edge at release
  always_ff @(posedge clk) req_q <= chan_req;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic sn, mn, rise, fall;
    assign rise = chan_req[c] & ~req_q[c];
    assign fall = ~chan_req[c] & req_q[c];
    always_comb begin
      sn = pend_stat[c] & ~cmd.clr_stat[c];
      mn = pend_mode[c] & ~cmd.clr_mode[c];
      // mode byte write reloads the status copy; it wins over the reverse reload
      if (cmd.touch_mode)      sn = mn;
      else if (cmd.touch_stat) mn = sn;
      // a request edge overrides any software clear in the same cycle
      if (rise) begin
        sn = 1'b1;
        mn = 1'b1;
      end else if (fall) begin
        sn = 1'b0;
        mn = 1'b0;
      end
    end
    assign stat_nx[c] = sn;
    assign mode_nx[c] = mn;
  end

  assign pend_next = mode_nx;
  assign blk_next  = cmd.blk_we ? cmd.blk_val : blk;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_stat <= '0;
      pend_mode <= '0;
      blk       <= '0;
    end else begin
      pend_stat <= stat_nx;
      pend_mode <= mode_nx;
      blk       <= blk_next;
    end
  end
endmodule

// File: rtl/ide_irq_out_stage.sv
module ide_irq_out_stage #(
  parameter int NUM_CHAN = 2
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NUM_CHAN-1:0] pend_next,
  input  logic [NUM_CHAN-1:0] blk_next,
  output logic                irq_out
);
  always_ff @(posedge clk) begin
    if (rst) irq_out <= 1'b0;
    else     irq_out <= |(pend_next & ~blk_next);
  end
endmodule

// File: rtl/ide_irq_rd_mux.sv
module ide_irq_rd_mux
  import ide_irq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cfg_rd,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [NUM_CHAN-1:0]     pend_stat,
  input  logic [NUM_CHAN-1:0]     pend_mode,
  input  logic [NUM_CHAN-1:0]     blk,
  input  logic [7:0]              chen_byte,
  output logic [8*DATA_BYTES-1:0] cfg_rdata
);
  localparam int LANE_W = $clog2(DATA_BYTES);

  logic [8*DATA_BYTES-1:0] rd_word;

  for (genvar g = 0; g < DATA_BYTES; g++) begin : g_lane
    logic [ADDR_W-1:0] lane_addr;
    logic [7:0]        lane_byte;
    assign lane_addr = {cfg_addr[ADDR_W-1:LANE_W], LANE_W'(g)};
    always_comb begin
      lane_byte = '0;
      case (lane_addr)
        ADDR_W'(OFS_PROGIF):  lane_byte = PROGIF_VAL;
        ADDR_W'(OFS_INTPIN):  lane_byte = INTPIN_VAL;
        ADDR_W'(OFS_CHEN):    lane_byte = chen_byte;
        ADDR_W'(OFS_CH0STAT): lane_byte[BIT_CH0STAT] = pend_stat[0];
        ADDR_W'(OFS_CH1STAT): lane_byte[BIT_CH1STAT] = pend_stat[1];
        ADDR_W'(OFS_MODE): begin
          lane_byte[BIT_MODE_PEND0 +: NUM_CHAN] = pend_mode;
          lane_byte[BIT_MODE_BLK0  +: NUM_CHAN] = blk;
        end
        default: lane_byte = '0;
      endcase
    end
    assign rd_word[8*g +: 8] = lane_byte;
  end

  always_ff @(posedge clk) begin
    if (rst)         cfg_rdata <= '0;
    else if (cfg_rd) cfg_rdata <= rd_word;
  end

  logic unused_lane_bits;
  assign unused_lane_bits = ^cfg_addr[LANE_W-1:0];
endmodule

// File: rtl/ide_irq_status_unit.sv
module ide_irq_status_unit
  import ide_irq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_BYTES = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    strap_sec_en,
  input  logic                    cfg_wr,
  input  logic                    cfg_rd,
  input  logic [ADDR_W-1:0]       cfg_addr,
  input  logic [DATA_BYTES-1:0]   cfg_be,
  input  logic [8*DATA_BYTES-1:0] cfg_wdata,
  output logic [8*DATA_BYTES-1:0] cfg_rdata,
  input  logic [NUM_CHAN-1:0]     chan_req,
  output logic                    irq_out
);
  wr_cmd_t             wr_cmd;
  logic [NUM_CHAN-1:0] pend_stat, pend_mode, blk, pend_next, blk_next;
  logic [7:0]          chen_q;

  // Channel-enable byte is captured from the strap while reset is held
  always_ff @(posedge clk) begin
    if (rst) chen_q <= CHEN_BASE | (strap_sec_en ? CHEN_SEC : 8'h00);
  end

  ide_irq_wr_decode #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) u_dec (
    .cfg_wr    (cfg_wr),
    .cfg_addr  (cfg_addr),
    .cfg_be    (cfg_be),
    .cfg_wdata (cfg_wdata),
    .cmd       (wr_cmd)
  );

  ide_irq_pend_core u_core (
    .clk       (clk),
    .rst       (rst),
    .cmd       (wr_cmd),
    .chan_req  (chan_req),
    .pend_stat (pend_stat),
    .pend_mode (pend_mode),
    .blk       (blk),
    .pend_next (pend_next),
    .blk_next  (blk_next)
  );

  ide_irq_out_stage #(.NUM_CHAN(NUM_CHAN)) u_out (
    .clk       (clk),
    .rst       (rst),
    .pend_next (pend_next),
    .blk_next  (blk_next),
    .irq_out   (irq_out)
  );

  ide_irq_rd_mux #(.ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)) u_rd (
    .clk       (clk),
    .rst       (rst),
    .cfg_rd    (cfg_rd),
    .cfg_addr  (cfg_addr),
    .pend_stat (pend_stat),
    .pend_mode (pend_mode),
    .blk       (blk),
    .chen_byte (chen_q),
    .cfg_rdata (cfg_rdata)
  );
endmodule

// File: rtl/ide_irq_status_chk.sv
module ide_irq_status_chk
  import ide_irq_pkg::*;
#(
  parameter int ADDR_W     = 8,
  parameter int DATA_BYTES = 4
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    cfg_wr,
  input logic [ADDR_W-1:0]       cfg_addr,
  input logic [DATA_BYTES-1:0]   cfg_be,
  input logic [8*DATA_BYTES-1:0] cfg_wdata,
  input logic [NUM_CHAN-1:0]     chan_req,
  input logic                    irq_out,
  input logic [NUM_CHAN-1:0]     pend_stat,
  input logic [NUM_CHAN-1:0]     pend_mode,
  input logic [NUM_CHAN-1:0]     blk
);
  localparam int LANE_W  = $clog2(DATA_BYTES);
  localparam int MD_LANE = int'(OFS_MODE) % DATA_BYTES;
  localparam logic [ADDR_W-1:0] MD_ADDR = ADDR_W'(OFS_MODE);

  logic mode_hit, clr_m0, clr_m1;
  assign mode_hit = cfg_wr && cfg_be[MD_LANE] &&
                    ((cfg_addr >> LANE_W) == (MD_ADDR >> LANE_W));
  assign clr_m0 = mode_hit && cfg_wdata[8*MD_LANE + BIT_MODE_PEND0];
  assign clr_m1 = mode_hit && cfg_wdata[8*MD_LANE + BIT_MODE_PEND0 + 1];

  // R1: quiet state right after reset
  p_reset_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!irq_out && pend_mode == '0 && pend_stat == '0 && blk == '0));

  // R4 / R5: the two copies of each pending bit never disagree
  p_copies_agree_r4: assert property (@(posedge clk) disable iff (rst)
    pend_stat == pend_mode);

  // R3: rising request edge sets, falling edge clears
  p_rise_sets0_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(chan_req[0]) |=> pend_mode[0]);
  p_rise_sets1_r3: assert property (@(posedge clk) disable iff (rst)
    $rose(chan_req[1]) |=> pend_mode[1]);
  p_fall_clears0_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(chan_req[0]) |=> !pend_mode[0]);
  p_fall_clears1_r3: assert property (@(posedge clk) disable iff (rst)
    $fell(chan_req[1]) |=> !pend_mode[1]);

  // R5: a one written at the mode byte clears unless a rising request overrides (R8)
  p_w1c_mode0_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_m0 && !$rose(chan_req[0])) |=> !pend_mode[0]);
  p_w1c_mode1_r5: assert property (@(posedge clk) disable iff (rst)
    (clr_m1 && !$rose(chan_req[1])) |=> !pend_mode[1]);

  // R6: output level follows the gated pending state
  p_irq_gate_r6: assert property (@(posedge clk) disable iff (rst)
    irq_out == |(pend_mode & ~blk));

  // R7: the output moves only when pending or block state moved at the same edge
  p_irq_moves_with_state_r7: assert property (@(posedge clk) disable iff (rst)
    (!$stable(irq_out) && !$past(rst)) |-> (!$stable(pend_mode) || !$stable(blk)));

  logic unused_chk;
  assign unused_chk = ^{cfg_wdata, cfg_be};
endmodule

bind ide_irq_status_unit ide_irq_status_chk #(
  .ADDR_W(ADDR_W), .DATA_BYTES(DATA_BYTES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cfg_wr    (cfg_wr),
  .cfg_addr  (cfg_addr),
  .cfg_be    (cfg_be),
  .cfg_wdata (cfg_wdata),
  .chan_req  (chan_req),
  .irq_out   (irq_out),
  .pend_stat (pend_stat),
  .pend_mode (pend_mode),
  .blk       (blk)
);

// File: tb/ide_irq_status_unit_bench.sv
`timescale 1ns/1ps
module ide_irq_status_unit_bench;
  localparam real CLK_NS = 8.0;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strap_sec_en = 1'b0;
  logic        cfg_wr = 1'b0;
  logic        cfg_rd = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [3:0]  cfg_be = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic [1:0]  chan_req = '0;
  logic        irq_out;

  int checks = 0;
  int errors = 0;

  // bench model
  logic [1:0] mp = '0;
  logic [1:0] mb = '0;
  logic [1:0] mreq = '0;
  logic       mirq = 1'b0;
  logic       mstrap = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  ide_irq_status_unit u_ide_irq_status_unit (
    .clk(clk), .rst(rst), .strap_sec_en(strap_sec_en),
    .cfg_wr(cfg_wr), .cfg_rd(cfg_rd), .cfg_addr(cfg_addr), .cfg_be(cfg_be),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .chan_req(chan_req),
    .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(input logic [7:0] a);
    case (a)
      8'h09: return 8'h8F;
      8'h3D: return 8'h01;
      8'h51: return mstrap ? 8'h0C : 8'h04;
      8'h50: return {5'b0, mp[0], 2'b0};
      8'h57: return {3'b0, mp[1], 4'b0};
      8'h71: return {2'b0, mb, mp, 2'b0};
      default: return 8'h00;
    endcase
  endfunction

  function automatic logic [31:0] exp_rd(input logic [7:0] a);
    logic [31:0] w;
    for (int k = 0; k < 4; k++) w[8*k +: 8] = exp_byte({a[7:2], 2'(k)});
    return w;
  endfunction

  task automatic model_step(input logic wr, input logic [7:0] a, input logic [3:0] be,
                            input logic [31:0] d, input logic [1:0] req);
    logic [1:0] np;
    np = mp;
    if (wr) begin
      if (a[7:2] == 6'h1C && be[1]) begin
        np = mp & ~d[11:10];
        mb = d[13:12];
      end else begin
        if (a[7:2] == 6'h14 && be[0] && d[2])  np[0] = 1'b0;
        if (a[7:2] == 6'h15 && be[3] && d[28]) np[1] = 1'b0;
      end
    end
    for (int c = 0; c < 2; c++) begin
      if (req[c] && !mreq[c])      np[c] = 1'b1;
      else if (!req[c] && mreq[c]) np[c] = 1'b0;
    end
    mreq = req;
    mp   = np;
    mirq = |(mp & ~mb);
  endtask

  task automatic cyc(input logic wr, input logic [7:0] a, input logic [3:0] be,
                     input logic [31:0] d, input logic [1:0] req, input string tag);
    logic prev_irq;
    @(negedge clk);
    prev_irq = mirq;
    cfg_wr = wr; cfg_rd = 1'b0; cfg_addr = a; cfg_be = be; cfg_wdata = d; chan_req = req;
    model_step(wr, a, be, d, req);
    #1;
    check({tag, " R7 no early change"}, {31'b0, irq_out}, {31'b0, prev_irq});
    @(posedge clk); #1;
    check(tag, {31'b0, irq_out}, {31'b0, mirq});
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    @(negedge clk);
    cfg_wr = 1'b0; cfg_rd = 1'b1; cfg_addr = a; chan_req = mreq;
    @(posedge clk); #1;
    check(tag, cfg_rdata, exp_rd(a));
  endtask

  task automatic do_reset(input logic strap);
    @(negedge clk);
    rst = 1'b1; strap_sec_en = strap; cfg_wr = 1'b0; cfg_rd = 1'b0; chan_req = 2'b00;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    mp = '0; mb = '0; mreq = '0; mirq = 1'b0; mstrap = strap;
    check("R1 irq low after reset", {31'b0, irq_out}, 32'h0);
  endtask

  initial begin
    #(CLK_NS * 150000);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h00C0FFEE);

    do_reset(1'b0);
    rd(8'h08, "R2 programming-interface byte");
    rd(8'h3C, "R2 interrupt-pin byte");
    rd(8'h50, "R2/R1 enable byte and ch0 status");
    rd(8'h70, "R1 mode byte clear");

    cyc(1'b0, 8'h00, 4'h0, 32'h0, 2'b01, "R3 rise ch0 raises irq");
    rd(8'h50, "R3 ch0 status set");
    rd(8'h70, "R3 ch0 mode copy set");
    cyc(1'b1, 8'h70, 4'h2, 32'h0000_0000, 2'b01, "R5 write zero keeps pending");
    cyc(1'b1, 8'h50, 4'h1, 32'h0000_0004, 2'b01, "R4 clear via status byte");
    rd(8'h70, "R4 mode copy follows status clear");

    cyc(1'b0, 8'h00, 4'h0, 32'h0, 2'b11, "R3 rise ch1");
    rd(8'h54, "R3 ch1 status set");
    cyc(1'b1, 8'h70, 4'h2, 32'h0000_2000, 2'b11, "R6 block ch1 drops irq");
    rd(8'h70, "R6 blocked ch1 stays pending");
    cyc(1'b1, 8'h70, 4'h2, 32'h0000_0800, 2'b11, "R5 clear ch1 via mode byte");
    rd(8'h54, "R5 ch1 status follows mode clear");

    cyc(1'b0, 8'h00, 4'h0, 32'h0, 2'b10, "R3 fall ch0 no pending change");
    cyc(1'b1, 8'h70, 4'h2, 32'h0000_1000, 2'b11, "R6 ch0 pending but blocked");
    cyc(1'b1, 8'h70, 4'h2, 32'h0000_0000, 2'b11, "R6 unblock raises irq");
    cyc(1'b1, 8'h50, 4'h1, 32'h0000_0004, 2'b01, "R3 fall ch1 with ch0 clear");
    cyc(1'b1, 8'h50, 4'h1, 32'h0000_0004, 2'b00, "R3 fall ch0");
    cyc(1'b1, 8'h50, 4'h1, 32'h0000_0004, 2'b01, "R8 rise beats same-cycle clear");
    rd(8'h70, "R8 pending survives clear");
    cyc(1'b0, 8'h00, 4'h0, 32'h0, 2'b00, "R3 fall ch0 clears irq");

    cyc(1'b1, 8'h50, 4'hF, 32'hFFFF_FFFB, 2'b00, "R2 write to enable byte");
    rd(8'h50, "R2 enable byte unchanged");
    cyc(1'b1, 8'h08, 4'hF, 32'hFFFF_FFFF, 2'b00, "R2 write to prog byte");
    rd(8'h08, "R2 prog byte unchanged");
    cyc(1'b1, 8'h3C, 4'hF, 32'h0000_0000, 2'b00, "R2 write to pin byte");
    rd(8'h3C, "R2 pin byte unchanged");
    rd(8'h64, "R9 unlisted offset reads zero");

    for (int i = 0; i < 600; i++) begin
      logic [7:0]  a;
      logic [1:0]  req;
      logic [31:0] d;
      case ($urandom_range(0, 5))
        0: a = 8'h08;
        1: a = 8'h3C;
        2: a = 8'h50;
        3: a = 8'h54;
        4: a = 8'h70;
        default: a = 8'h64;
      endcase
      req = mreq;
      if ($urandom_range(0, 4) == 0) req[0] = ~req[0];
      if ($urandom_range(0, 4) == 0) req[1] = ~req[1];
      d = $urandom;
      cyc(1'($urandom_range(0, 1)), a, 4'($urandom_range(0, 15)), d, req, "R6 random irq level");
      if (i % 10 == 9) begin
        rd(8'h50, "R4 random status ch0 read");
        rd(8'h54, "R4 random status ch1 read");
        rd(8'h70, "R5 random mode read");
      end
    end

    do_reset(1'b1);
    rd(8'h50, "R2 strap reports second channel");
    rd(8'h70, "R1 mode byte clear after second reset");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule